// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken, given its program counter. It runs two predictors side by side. The local predictor keeps a short outcome history for each branch, selected by low PC bits, and uses that history to pick a 3-bit saturating counter. The global predictor uses a path-wide history register to pick a 2-bit saturating counter. A third table of 2-bit counters, also indexed by the global history, learns which of the two predictors has been more reliable in that context, and its most significant bit chooses the final answer.

One lookup and one resolved-branch update can happen in each cycle. A lookup returns the prediction at once, together with the global and local history values it used. The fetch logic keeps these values with the branch and hands them back on the update port when the branch resolves. The global history is advanced speculatively with every prediction. When a resolved branch is flagged as mispredicted, the register is rebuilt from the returned snapshot and the true outcome. Default sizes: 1,024 local histories of 10 bits, 1,024 local counters, and 4,096-entry global and choice tables addressed by 12 history bits.

Top module: `tourney_bp`

## Requirements
- R1: After reset every lookup predicts not-taken and returns all-zero histories. Every counter starts at weakly not-taken: 3 for a 3-bit counter, 1 for a 2-bit counter. Every history starts at zero.
- R2: In a cycle with a lookup and no mispredict recovery, the global history takes the predicted direction as its new least significant bit (1 = taken), and the older bits move up by one place. In a cycle with neither a lookup nor a recovery, the global history does not change.
- R3: When an update is flagged as a mispredict, the next global history is the returned snapshot shifted left by one with the actual outcome as the new least significant bit. This takes priority over a lookup in the same cycle.
- R4: Each update shifts the actual outcome into the least significant bit of the local history entry selected by PC bits [PC_LSB +: LIDX_W] of the update PC.
- R5: Each update moves the local counter selected by the returned local history one step toward the outcome, saturating at 0 and 7. The local predictor says taken when that counter is 4 or more.
- R6: Each update moves the global counter selected by the returned global history one step toward the outcome, saturating at 0 and 3. The global predictor says taken when that counter is 2 or more.
- R7: The choice counter selected by the returned global history changes only when the local and global predictors disagree at update time. It steps up (toward global) when the global predictor was right and steps down otherwise, saturating at 0 and 3.
- R8: The lookup prediction is the global predictor's answer when the choice counter at the current global history is 2 or more, and the local predictor's answer otherwise. Tables read their state from before any same-cycle update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is made this cycle; advances the global history |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_ghist | output | GHIST_W | Global history used by this lookup |
| lk_lhist | output | LHIST_W | Local history used by this lookup |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_mispredict | input | 1 | The branch was mispredicted; triggers history recovery |
| up_ghist | input | GHIST_W | Global history returned from the branch's lookup |
| up_lhist | input | LHIST_W | Local history returned from the branch's lookup |

## Verification
The bench builds the predictor with 3 PC index bits, 4-bit local histories and a 5-bit global history. With these sizes every table has at most 32 entries, so a few hundred branches drive counters into both saturation limits and make the history registers wrap many times. Several PCs share local history entries, so aliasing is exercised. Mispredict recovery often coincides with a lookup, and the choice counters swing both ways within the run.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef enum logic {
      TBP_SEL_LOCAL  = 1'b0,
      TBP_SEL_GLOBAL = 1'b1
   } tbp_sel_e;

   localparam int unsigned TBP_MAX_CTR_W  = 8;
   localparam int unsigned TBP_MAX_HIST_W = 16;
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int unsigned IDX_W = 12,
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic [IDX_W-1:0] wr_idx,
   output logic [CTR_W-1:0] wr_cur,
   input  logic             wr_en,
   input  logic             wr_up
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX  = '1;
   localparam logic [CTR_W-1:0] CTR_WEAK = CTR_MAX >> 1;

   if (CTR_W < 2 || CTR_W > tbp_pkg::TBP_MAX_CTR_W) begin : g_bad_ctr_w
      $error("tbp_ctr_table: CTR_W out of range");
   end

   logic [CTR_W-1:0] mem [DEPTH];
   logic [CTR_W-1:0] wr_next;

   assign rd_ctr = mem[rd_idx];
   assign wr_cur = mem[wr_idx];

   always_comb begin
      wr_next = wr_cur;
      if (wr_up && wr_cur != CTR_MAX) begin
         wr_next = wr_cur + 1'b1;
      end else if (!wr_up && wr_cur != '0) begin
         wr_next = wr_cur - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= CTR_WEAK;
         end
      end else if (wr_en) begin
         mem[wr_idx] <= wr_next;
      end
   end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (HIST_W < 2 || HIST_W > tbp_pkg::TBP_MAX_HIST_W) begin : g_bad_hist_w
      $error("tbp_hist_table: HIST_W out of range");
   end

   logic [HIST_W-1:0] mem [DEPTH];

   assign rd_hist = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
      end else if (wr_en) begin
         mem[wr_idx] <= {mem[wr_idx][HIST_W-2:0], wr_bit};
      end
   end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned PC_LSB  = 2,
   parameter int unsigned LIDX_W  = 10,
   parameter int unsigned LHIST_W = 10,
   parameter int unsigned LCTR_W  = 3,
   parameter int unsigned GHIST_W = 12,
   parameter int unsigned GCTR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [PC_W-1:0]    lk_pc,
   output logic               lk_taken,
   output logic [GHIST_W-1:0] lk_ghist,
   output logic [LHIST_W-1:0] lk_lhist,
   input  logic               up_valid,
   input  logic [PC_W-1:0]    up_pc,
   input  logic               up_taken,
   input  logic               up_mispredict,
   input  logic [GHIST_W-1:0] up_ghist,
   input  logic [LHIST_W-1:0] up_lhist
);
   import tbp_pkg::*;

   if (PC_LSB + LIDX_W > PC_W) begin : g_bad_pc_slice
      $error("tourney_bp: PC index slice exceeds PC_W");
   end
   if (GHIST_W < 2) begin : g_bad_ghist_w
      $error("tourney_bp: GHIST_W must be at least 2");
   end

   logic [LIDX_W-1:0]  lk_lidx, up_lidx;
   logic [LCTR_W-1:0]  l_rd, l_wr;
   logic [GCTR_W-1:0]  g_rd, g_wr;
   logic [1:0]         c_rd, c_wr;
   logic [GHIST_W-1:0] ghr_q, ghr_d;
   logic               l_up_pred, g_up_pred;
   tbp_sel_e           sel;

   assign lk_lidx = lk_pc[PC_LSB +: LIDX_W];
   assign up_lidx = up_pc[PC_LSB +: LIDX_W];

   tbp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lht (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_lidx), .rd_hist(lk_lhist),
      .wr_en(up_valid), .wr_idx(up_lidx), .wr_bit(up_taken)
   );

   tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_lhist), .rd_ctr(l_rd),
      .wr_idx(up_lhist), .wr_cur(l_wr),
      .wr_en(up_valid), .wr_up(up_taken)
   );

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghr_q), .rd_ctr(g_rd),
      .wr_idx(up_ghist), .wr_cur(g_wr),
      .wr_en(up_valid), .wr_up(up_taken)
   );

   assign l_up_pred = l_wr[LCTR_W-1];
   assign g_up_pred = g_wr[GCTR_W-1];

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(2)) u_cctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghr_q), .rd_ctr(c_rd),
      .wr_idx(up_ghist), .wr_cur(c_wr),
      .wr_en(up_valid && (l_up_pred != g_up_pred)),
      .wr_up(g_up_pred == up_taken)
   );

   assign sel      = c_rd[1] ? TBP_SEL_GLOBAL : TBP_SEL_LOCAL;
   assign lk_taken = (sel == TBP_SEL_GLOBAL) ? g_rd[GCTR_W-1] : l_rd[LCTR_W-1];
   assign lk_ghist = ghr_q;

   always_comb begin
      ghr_d = ghr_q;
      if (up_valid && up_mispredict) begin
         ghr_d = {up_ghist[GHIST_W-2:0], up_taken};
      end else if (lk_valid) begin
         ghr_d = {ghr_q[GHIST_W-2:0], lk_taken};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ghr_q <= '0;
      end else begin
         ghr_q <= ghr_d;
      end
   end
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned PC_LSB  = 2,
   parameter int unsigned LIDX_W  = 10,
   parameter int unsigned LHIST_W = 10,
   parameter int unsigned LCTR_W  = 3,
   parameter int unsigned GHIST_W = 12,
   parameter int unsigned GCTR_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [PC_W-1:0]    lk_pc,
   input logic               lk_taken,
   input logic [GHIST_W-1:0] lk_ghist,
   input logic [LHIST_W-1:0] lk_lhist,
   input logic               up_valid,
   input logic [PC_W-1:0]    up_pc,
   input logic               up_taken,
   input logic               up_mispredict,
   input logic [GHIST_W-1:0] up_ghist,
   input logic [LHIST_W-1:0] up_lhist
);
   logic recov;
   assign recov = up_valid && up_mispredict;

   // R1: global history is zero on the first cycle out of reset
   a_r1_ghist_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> lk_ghist == '0);

   // R2: a lookup shifts its own prediction into the global history
   a_r2_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !recov) |=>
         lk_ghist == {$past(lk_ghist[GHIST_W-2:0]), $past(lk_taken)});

   // R2: no lookup and no recovery leaves the global history alone
   a_r2_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_valid && !recov) |=> $stable(lk_ghist));

   // R3: recovery rebuilds the history from the snapshot and outcome
   a_r3_recover: assert property (@(posedge clk) disable iff (!rst_n)
      recov |=> lk_ghist == {$past(up_ghist[GHIST_W-2:0]), $past(up_taken)});

   // R4: an update to the entry being looked up shifts in the outcome
   a_r4_lhist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && lk_pc[PC_LSB +: LIDX_W] == up_pc[PC_LSB +: LIDX_W]) |=>
         (lk_pc[PC_LSB +: LIDX_W] != $past(lk_pc[PC_LSB +: LIDX_W])) ||
         (lk_lhist == {$past(lk_lhist[LHIST_W-2:0]), $past(up_taken)}));
endmodule

bind tourney_bp tourney_bp_chk #(
   .PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W),
   .LCTR_W(LCTR_W), .GHIST_W(GHIST_W), .GCTR_W(GCTR_W)
) u_chk (.*);

// File: tb/tourney_bp_bench.sv
module tourney_bp_bench;
   localparam int PC_W    = 16;
   localparam int PC_LSB  = 2;
   localparam int LIDX_W  = 3;
   localparam int LHIST_W = 4;
   localparam int LCTR_W  = 3;
   localparam int GHIST_W = 5;
   localparam int GCTR_W  = 2;
   localparam int LDEP  = 1 << LIDX_W;
   localparam int LCDEP = 1 << LHIST_W;
   localparam int GDEP  = 1 << GHIST_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               lk_valid = 1'b0;
   logic [PC_W-1:0]    lk_pc = '0;
   logic               lk_taken;
   logic [GHIST_W-1:0] lk_ghist;
   logic [LHIST_W-1:0] lk_lhist;
   logic               up_valid = 1'b0;
   logic [PC_W-1:0]    up_pc = '0;
   logic               up_taken = 1'b0;
   logic               up_mispredict = 1'b0;
   logic [GHIST_W-1:0] up_ghist = '0;
   logic [LHIST_W-1:0] up_lhist = '0;

   always #4 clk = ~clk;

   tourney_bp #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W),
                .LCTR_W(LCTR_W), .GHIST_W(GHIST_W), .GCTR_W(GCTR_W)) u_tourney_bp (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_ghist(lk_ghist), .lk_lhist(lk_lhist),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_mispredict(up_mispredict), .up_ghist(up_ghist), .up_lhist(up_lhist)
   );

   // behavioural reference state
   int lht_m [LDEP];
   int lc_m  [LCDEP];
   int gc_m  [GDEP];
   int cc_m  [GDEP];
   int ghr_m;

   typedef struct {
      int pc;
      int gh;
      int lh;
      bit pred;
      bit outcome;
   } rec_t;
   rec_t pend[$];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat(int v, bit up, int maxv);
      if (up) return (v < maxv) ? v + 1 : v;
      return (v > 0) ? v - 1 : v;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < LDEP; i++) lht_m[i] = 0;
      for (int i = 0; i < LCDEP; i++) lc_m[i] = 3;
      for (int i = 0; i < GDEP; i++) begin
         gc_m[i] = 1;
         cc_m[i] = 1;
      end
      ghr_m = 0;
      pend.delete();
   endtask

   // one cycle: optional lookup, resolve oldest pending branch when deep enough
   task automatic step(bit lv, int pc, bit outcome, string req);
      rec_t r, nr;
      bit   uv, mis, p, lp, gp;
      int   lh, gh, li;
      uv  = (pend.size() >= 2);
      if (uv) r = pend.pop_front();
      mis = uv && (r.outcome != r.pred);
      @(negedge clk);
      lk_valid      = lv;
      lk_pc         = PC_W'(pc);
      up_valid      = uv;
      up_pc         = uv ? PC_W'(r.pc) : '0;
      up_ghist      = uv ? GHIST_W'(r.gh) : '0;
      up_lhist      = uv ? LHIST_W'(r.lh) : '0;
      up_taken      = uv ? r.outcome : 1'b0;
      up_mispredict = mis;
      #1;
      li = (pc >> PC_LSB) & (LDEP - 1);
      lh = lht_m[li];
      gh = ghr_m;
      lp = lc_m[lh] >= 4;
      gp = gc_m[gh] >= 2;
      p  = (cc_m[gh] >= 2) ? gp : lp;
      chk(req, int'(lk_taken), int'(p));          // R8 selection of component
      chk("R2_R3 ghist", int'(lk_ghist), gh);
      chk("R4 lhist", int'(lk_lhist), lh);
      @(posedge clk);
      if (uv) begin
         bit ulp, ugp;
         int ui;
         ulp = lc_m[r.lh] >= 4;
         ugp = gc_m[r.gh] >= 2;
         if (ulp != ugp) cc_m[r.gh] = sat(cc_m[r.gh], ugp == r.outcome, 3);   // R7
         lc_m[r.lh] = sat(lc_m[r.lh], r.outcome, 7);                         // R5
         gc_m[r.gh] = sat(gc_m[r.gh], r.outcome, 3);                         // R6
         ui = (r.pc >> PC_LSB) & (LDEP - 1);
         lht_m[ui] = ((lht_m[ui] << 1) | int'(r.outcome)) & (LCDEP - 1);
      end
      if (mis) ghr_m = ((r.gh << 1) | int'(r.outcome)) & (GDEP - 1);
      else if (lv) ghr_m = ((ghr_m << 1) | int'(p)) & (GDEP - 1);
      if (lv) begin
         nr.pc = pc; nr.gh = gh; nr.lh = lh; nr.pred = p; nr.outcome = outcome;
         pend.push_back(nr);
      end
      if (mis) pend.delete();
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state seen at the ports
      chk("R1 taken", int'(lk_taken), 0);
      chk("R1 ghist", int'(lk_ghist), 0);
      chk("R1 lhist", int'(lk_lhist), 0);

      // R5: one branch always taken, local counter climbs to saturation
      for (int i = 0; i < 40; i++) step(1'b1, 'h14, 1'b1, "R5 local train");
      // R5: then always not-taken, counter falls to zero
      for (int i = 0; i < 40; i++) step(1'b1, 'h14, 1'b0, "R5 local untrain");
      // R7: alternating branch, local and global disagree often
      for (int i = 0; i < 80; i++) step(1'b1, 'h20, i[0], "R7 choice");
      // R6: outcome follows the global path, branches alternate in PC
      for (int i = 0; i < 120; i++)
         step(1'b1, 'h40 + 4 * (i % 3), ghr_m[0] ^ ghr_m[2], "R6 global corr");
      // R2: idle cycles interleaved with lookups
      for (int i = 0; i < 40; i++) step(i % 3 != 0, 'h8, 1'b1, "R2 idle mix");
      // R8: mixed traffic with aliasing PCs
      for (int i = 0; i < 600; i++) begin
         int pc;
         bit t, lv;
         pc = 4 * ($urandom % 12);
         t  = (pc % 8 == 0) ? 1'b1 : ((($urandom % 4) != 0) ^ bit'(ghr_m[1]));
         lv = ($urandom % 10) != 0;
         step(lv, pc, t, "R8 mixed");
      end
      // R3: drain remaining updates without lookups
      for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, "R3 drain");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule